// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets a host reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface. The host programs a transaction through a small byte-wide register bus. It writes the data bytes, then the register number with the low PHY address bits, then a final control byte. That control byte carries the high PHY address bits, the direction bit and a start bit. The block then serializes one clause-22 management frame. A read returns its 16 data bits and a failure flag in status bytes.

The start bit is also the busy flag. It reads back as 1 while the frame is on the wire and clears by itself when the last bit has been clocked. MDC comes from the system clock through a divider of `HALF_DIV` system cycles per half period. It runs only while the enable bit in the core control byte is set. When that bit is clear, MDC holds its level and any frame in progress pauses.

The frame sequencer has six states:
- ST_IDLE: waits for a start. On a start it goes to ST_ARM.
- ST_ARM: waits for the next MDC falling edge. On that edge it goes to ST_PRE and launches bit 0.
- ST_PRE: sends the preamble. At the fall that ends bit 31 it goes to ST_HDR.
- ST_HDR: sends start, opcode, PHY and register. At the fall that ends bit 45 it goes to ST_TA.
- ST_TA: the turnaround. At the fall that ends bit 47 it goes to ST_DATA.
- ST_DATA: the 16 data bits. At the fall that ends bit 63 it returns to ST_IDLE and busy clears.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register map (address, content):
  - Address 0: write data bits 7:0.
  - Address 1: write data bits 15:8.
  - Address 2: PHY address bits 2:0 in bits 7:5, and the register number in bits 4:0.
  - Address 3: bit 7 is start/busy, bit 2 is the direction (1 = write, 0 = read), and bits 1:0 are PHY address bits 4:3. It reads back as {busy, 0000, direction, PHY[4:3]}.
  - Address 8 (core control): bit 4 is the MDC enable.
- R2: A write to address 3 with bit 7 set, made while idle, starts a frame. Address 3 bit 7 reads 1 from the next cycle. It falls to 0 on the same clock edge as the MDC fall that ends the last frame bit.
- R3: While busy, a write to address 3 is ignored. The readback of its bits stays the same, and the frame in progress is unchanged.
- R4: The first 46 frame bits are driven MSB first, each launched on an MDC fall. They are, in order:
  - 32 ones (preamble);
  - 01 (start);
  - opcode 10 for a read or 01 for a write;
  - the 5-bit PHY address;
  - the 5-bit register number.
- R5: On a write, the master also drives turnaround 10 and then the 16 data bits MSB first. MDIO output enable stays high for all 64 bits.
- R6: On a read, the output enable is low from bit 46 to the end. The 16 bits sampled on the MDC rises of bits 48..63 appear MSB first: the low byte at address 4 and the high byte at address 5.
- R7: Address 7 bit 7 is the read-failure flag. It is set if MDIO is high at the MDC rise of bit 47 (the second turnaround bit) of a read, and cleared when any frame starts. Address 6 reads 0.
- R8: MDC changes level only every `HALF_DIV` system cycles while the enable bit is set. While the bit is clear, MDC holds its level and a started frame stalls, busy remaining set.
- R9: MDIO out changes only on the clock edge where MDC falls.
- R10: After reset, the outputs and readbacks are:
  - MDC low and output enable low;
  - MDIO out high;
  - address 3, the status bytes and the core control byte all read 0.
- R11: With MDC enabled, a frame completes within 2*HALF_DIV*65 system cycles of its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Some properties are checked on every cycle:
- MDIO out moves only on MDC falls, and the output enable rises only on an MDC fall.
- MDC never toggles unless the enable bit was set.
- Busy always clears together with an MDC fall.
- Writes to the control byte during a transaction change nothing.

Only the bench scenarios can show the following:
- the bit content of each frame, over a sweep of every PHY address and every register number;
- the returned read data;
- the turnaround failure flag and its clearing;
- the stall with MDC disabled;
- the completion bound.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_LAST   = 31;
    localparam int HDR_LAST   = 45;
    localparam int TA_LAST    = 47;
    localparam int DATA_LAST  = 63;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end    = (cnt_q == CW'(HALF_DIV - 1));
    assign rise_tick = en && at_end && !mdc;
    assign fall_tick = en && at_end && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (en) begin
            if (at_end) begin
                cnt_q <= '0;
                mdc   <= ~mdc;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: a cleared enable freezes the clock level
    p_mdc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_wr,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata,
    output logic        rd_fail
);
    mdio_state_e state_q, state_d;
    logic [5:0]  idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic        wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ARM;
            ST_ARM:  if (fall_tick) state_d = ST_PRE;
            ST_PRE:  if (fall_tick && idx_q == 6'(PRE_LAST))  state_d = ST_HDR;
            ST_HDR:  if (fall_tick && idx_q == 6'(HDR_LAST))  state_d = ST_TA;
            ST_TA:   if (fall_tick && idx_q == 6'(TA_LAST))   state_d = ST_DATA;
            ST_DATA: if (fall_tick && idx_q == 6'(DATA_LAST)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = shreg_q[FRAME_BITS-1];
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_PRE, ST_HDR: mdio_oe = 1'b1;
            ST_TA, ST_DATA: mdio_oe = wr_q;
            default:        mdio_oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            rdata   <= '0;
            rd_fail <= 1'b0;
        end else begin
            if (start && state_q == ST_IDLE) begin
                shreg_q <= {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad,
                            (is_wr ? {2'b10, wdata} : 18'h3FFFF)};
                wr_q    <= is_wr;
                idx_q   <= '0;
                rd_fail <= 1'b0;
            end else if (fall_tick && state_q != ST_IDLE && state_q != ST_ARM) begin
                shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
                idx_q   <= idx_q + 1'b1;
            end
            if (rise_tick && !wr_q) begin
                if (state_q == ST_TA && idx_q == 6'(TA_LAST)) rd_fail <= mdio_i;
                if (state_q == ST_DATA) rdata <= {rdata[14:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master #(
    parameter int HALF_DIV = 2,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [ADDR_W-1:0] A_WD_LO = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_WD_HI = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PHYRG = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_RD_LO = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_RD_HI = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_ST2   = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_ST3   = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_CORE  = ADDR_W'(8);

    logic [7:0]  wd_lo_q, wd_hi_q, phyrg_q;
    logic [1:0]  phy_hi_q;
    logic        dir_wr_q;
    logic        mdc_en_q;
    logic        busy, start, rise_tick, fall_tick, rd_fail;
    logic [15:0] rdata;
    logic        unused_bits;

    assign unused_bits = ^reg_wdata[6:3];
    assign start = reg_wr && (reg_addr == A_CTRL) && reg_wdata[7] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_lo_q  <= '0;
            wd_hi_q  <= '0;
            phyrg_q  <= '0;
            phy_hi_q <= '0;
            dir_wr_q <= 1'b0;
            mdc_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_WD_LO) wd_lo_q <= reg_wdata;
            if (reg_addr == A_WD_HI) wd_hi_q <= reg_wdata;
            if (reg_addr == A_PHYRG) phyrg_q <= reg_wdata;
            if (reg_addr == A_CTRL && !busy) begin
                phy_hi_q <= reg_wdata[1:0];
                dir_wr_q <= reg_wdata[2];
            end
            if (reg_addr == A_CORE) mdc_en_q <= reg_wdata[4];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_addr)
            A_WD_LO: reg_rdata = wd_lo_q;
            A_WD_HI: reg_rdata = wd_hi_q;
            A_PHYRG: reg_rdata = phyrg_q;
            A_CTRL:  reg_rdata = {busy, 4'b0000, dir_wr_q, phy_hi_q};
            A_RD_LO: reg_rdata = rdata[7:0];
            A_RD_HI: reg_rdata = rdata[15:8];
            A_ST2:   reg_rdata = 8'h00;
            A_ST3:   reg_rdata = {rd_fail, 7'b0};
            A_CORE:  reg_rdata = {3'b000, mdc_en_q, 4'b0000};
            default: reg_rdata = 8'h00;
        endcase
    end

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mdc_en_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_wr     (reg_wdata[2]),
        .phy       ({reg_wdata[1:0], phyrg_q[7:5]}),
        .regad     (phyrg_q[4:0]),
        .wdata     ({wd_hi_q, wd_lo_q}),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (rdata),
        .rd_fail   (rd_fail)
    );

    // R9: the data line only moves with a falling management clock
    p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));
    // R5: the driver is switched on at a falling edge
    p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $fell(mdc));
    // R2: busy ends together with the last falling edge
    p_done_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));
    // R8: no clock activity without the enable bit
    p_mdc_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(mdc_en_q));
    // R3: control byte held during a transaction
    p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && busy) |=> $stable({dir_wr_q, phy_hi_q}));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int BOUND      = 2 * HALF_DIV * 65;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mdc, mdio_o, mdio_oe;
    logic       mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // PHY model state
    bit          armed = 0;
    bit          active = 0;
    int          rise_cnt = 0;
    logic [63:0] cap, oecap;
    logic [15:0] phy_data;
    logic        phy_ta;
    logic [63:0] exp_frame;
    logic        exp_wr;
    int          r9_bad = 0;

    mdio_mgmt_master #(.HALF_DIV(HALF_DIV), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic phy_bit(input int n);
        if (n == 47) return phy_ta;
        if (n >= 48 && n <= 63) return phy_data[63-n];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (armed && (mdio_oe || active)) begin
            active = 1;
            cap    = {cap[62:0], mdio_o};
            oecap  = {oecap[62:0], mdio_oe};
            rise_cnt = rise_cnt + 1;
            mdio_i <= phy_bit(rise_cnt);
            if (rise_cnt == 64) begin
                active = 0;
                armed  = 0;
            end
        end
    end

    // R9 monitor: data line changes only where the clock falls
    logic prev_o = 1'b1, prev_mdc = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mdio_o !== prev_o && !(prev_mdc == 1'b1 && mdc == 1'b0))
            r9_bad++;
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_txn(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] data, input logic ta);
        logic [7:0] v;
        reg_write(4'd0, data[7:0]);
        reg_write(4'd1, data[15:8]);
        reg_write(4'd2, {phy[2:0], ra});
        phy_data = data; phy_ta = ta;
        exp_wr = wr;
        exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, data};
        cap = '0; oecap = '0; rise_cnt = 0; active = 0; armed = 1; mdio_i = 1'b1;
        reg_write(4'd3, {1'b1, 4'b0000, wr, phy[4:3]});
        reg_read(4'd3, v);
        chk("R2 busy after start", {56'd0, v}, {56'd0, 1'b1, 4'b0000, wr, phy[4:3]});
    endtask

    task automatic finish_txn(input logic [4:0] phy);
        logic [7:0] v, lo, hi;
        int cyc = 0;
        do begin
            reg_read(4'd3, v);
            cyc++;
        end while (v[7] && cyc < 4 * BOUND);
        chk("R11 completion bound", {63'd0, (cyc <= BOUND)}, 64'd1);
        chk("R1 control readback", {56'd0, v}, {56'd0, 1'b0, 4'b0000, exp_wr, phy[4:3]});
        repeat (2 * HALF_DIV) @(negedge clk);
        chk("R4 frame header bits", {18'd0, cap[63:18]}, {18'd0, exp_frame[63:18]});
        if (exp_wr) begin
            chk("R5 write frame", cap, exp_frame);
            chk("R5 write enable", oecap, {64{1'b1}});
            reg_read(4'd7, v);
            chk("R7 flag cleared by start", {56'd0, v}, 64'd0);
        end else begin
            chk("R6 read enable pattern", oecap, {{46{1'b1}}, 18'd0});
            reg_read(4'd4, lo);
            reg_read(4'd5, hi);
            chk("R6 read data", {48'd0, hi, lo}, {48'd0, phy_data});
            reg_read(4'd7, v);
            chk("R7 turnaround flag", {56'd0, v}, {56'd0, phy_ta, 7'd0});
            reg_read(4'd6, v);
            chk("R7 status byte 2 zero", {56'd0, v}, 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       m0;
        int         hp;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk("R10 mdc", {63'd0, mdc}, 64'd0);
        chk("R10 oe", {63'd0, mdio_oe}, 64'd0);
        chk("R10 mdio_o", {63'd0, mdio_o}, 64'd1);
        rst_n = 1'b1;
        reg_read(4'd3, v); chk("R10 ctrl", {56'd0, v}, 64'd0);
        reg_read(4'd4, v); chk("R10 status0", {56'd0, v}, 64'd0);
        reg_read(4'd5, v); chk("R10 status1", {56'd0, v}, 64'd0);
        reg_read(4'd7, v); chk("R10 status3", {56'd0, v}, 64'd0);
        reg_read(4'd8, v); chk("R10 core", {56'd0, v}, 64'd0);
        repeat (10) @(negedge clk);
        chk("R8 mdc idle when disabled", {63'd0, mdc}, 64'd0);

        reg_write(4'd8, 8'h10);
        reg_read(4'd8, v); chk("R8 core enable readback", {56'd0, v}, 64'h10);

        // R8 half period
        @(negedge clk); m0 = mdc;
        while (mdc == m0) @(negedge clk);
        m0 = mdc; hp = 0;
        while (mdc == m0) begin @(negedge clk); hp++; end
        chk("R8 half period", 64'(hp), 64'(HALF_DIV));

        // R1 data byte readback
        reg_write(4'd0, 8'h3C); reg_read(4'd0, v); chk("R1 byte0", {56'd0, v}, 64'h3C);
        reg_write(4'd2, 8'hE7); reg_read(4'd2, v); chk("R1 byte2", {56'd0, v}, 64'hE7);

        // Sweep: writes over every PHY address
        for (int p = 0; p < 32; p++) begin
            start_txn(1'b1, 5'(p), 5'(31 - p), 16'(p * 16'h0841) ^ 16'hA5C3, 1'b0);
            finish_txn(5'(p));
        end
        // Sweep: reads over every register number
        for (int r = 0; r < 32; r++) begin
            start_txn(1'b0, 5'(r) ^ 5'h15, 5'(r), {5'(r), ~5'(r), 6'b101010}, 1'b0);
            finish_txn(5'(r) ^ 5'h15);
        end
        // Data extremes
        start_txn(1'b0, 5'h1F, 5'h00, 16'h0000, 1'b0); finish_txn(5'h1F);
        start_txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b0); finish_txn(5'h00);

        // R7 failed turnaround, then cleared by the next frame
        start_txn(1'b0, 5'h0A, 5'h02, 16'h8001, 1'b1); finish_txn(5'h0A);
        start_txn(1'b1, 5'h0B, 5'h03, 16'h1234, 1'b0); finish_txn(5'h0B);

        // R3 control write ignored while busy
        start_txn(1'b1, 5'h1A, 5'h03, 16'h5AA5, 1'b0);
        repeat (20) @(negedge clk);
        reg_write(4'd3, 8'h80);
        reg_read(4'd3, v);
        chk("R3 busy write ignored", {56'd0, v}, 64'h87);
        finish_txn(5'h1A);

        // R8 stall with the clock disabled
        reg_write(4'd8, 8'h00);
        repeat (4) @(negedge clk);
        m0 = mdc;
        start_txn(1'b0, 5'h05, 5'h11, 16'hC3E1, 1'b0);
        repeat (40) @(negedge clk);
        chk("R8 mdc held", {63'd0, mdc}, {63'd0, m0});
        chk("R8 no bits sent", 64'(rise_cnt), 64'd0);
        chk("R8 oe low while stalled", {63'd0, mdio_oe}, 64'd0);
        reg_read(4'd3, v);
        chk("R8 still busy", {63'd0, v[7]}, 64'd1);
        reg_write(4'd8, 8'h10);
        finish_txn(5'h05);

        chk("R9 data changes only on mdc fall", 64'(r9_bad), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule